// File: doc/BRIEF.md
# Frame-Sync Period Validator and Frame Pulse Regenerator

This block runs entirely in the reference clock domain. Its frame-sync input is produced from that same reference clock. The block finds each rising edge of the sync input and counts the reference cycles between successive edges. It accepts the sync only when that count equals the nominal frame length for the selected rate: 1024 cycles for 8 kHz framing or 4096 cycles for 2 kHz framing, both at an 8.192 MHz reference. An active-low frame pulse can be used as the sync input because a polarity control inverts the input before edge detection.

Each detected sync edge produces a one-cycle boundary strobe on the first reference edge after the synchronised sync edge. Once a frame has been accepted, a frame counter regenerates an output frame pulse every nominal period. That counter is re-snapped to every validated boundary. When a different reference/sync pair is selected, validation and framing restart immediately and no phase correction carries over. Framing then follows the new pair's sync alone.

Top module: `frame_pair_checker`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `valid`, `bnd_stb` and `frame_pulse` are 0.
- R2: With `sync_inv`=1, a falling edge on `sync_in` is treated as the sync edge. The strobe timing is the same as in R3.
- R3: A sync edge driven just after reference edge N gives `bnd_stb` high for exactly one cycle, starting at reference edge N+3.
- R4: With `rate_slow`=0, `valid` rises at the boundary strobe that closes a period of exactly 1024 reference cycles.
- R5: At any boundary that closes a period other than nominal (for example 1023 or 1025 cycles), `valid` is 0 from that strobe onward.
- R6: With `rate_slow`=1, the nominal period is 4096 reference cycles.
- R7: While valid, `frame_pulse` is high for PULSE_LEN (4) cycles, starting in the strobe cycle of a validated boundary. Without further sync edges it recurs every nominal period.
- R8: If no sync edge arrives within nominal + MARGIN (16) cycles of the last one, `valid` drops.
- R9: A `pair_chg` strobe with `pair_sel` different from the current pair clears `valid` and `frame_pulse` on the next cycle. Validation then needs a fresh edge plus one exact period.
- R10: A `pair_chg` strobe with `pair_sel` equal to the current pair has no effect. `valid` stays high and framing continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | Frame-sync input derived from the reference clock |
| sync_inv | input | 1 | 1 inverts `sync_in` before edge detection |
| rate_slow | input | 1 | 0: 8 kHz framing (1024 cycles); 1: 2 kHz framing (4096 cycles) |
| pair_sel | input | 1 | Selected reference/sync pair |
| pair_chg | input | 1 | Strobe announcing a pair selection |
| valid | output | 1 | Sync period validated |
| bnd_stb | output | 1 | One-cycle frame boundary strobe |
| frame_pulse | output | 1 | Regenerated, aligned output frame pulse |

## Verification
The embedded properties check several rules on every cycle:
- the boundary strobe never lasts more than one cycle;
- `valid` only rises on a boundary strobe;
- a valid boundary always carries the start of a frame pulse;
- a pair switch clears the outputs;
- an overdue edge releases `valid`.

Only the bench scenarios can show whether the cycle count is judged exactly, including the off-by-one periods and the slow rate. The same holds for the recurrence spacing of the regenerated pulse and for the exact three-cycle latency under both polarities.

// File: rtl/frame_pair_checker.sv
module frame_pair_checker #(
  parameter int NOM_FAST  = 1024,
  parameter int NOM_SLOW  = 4096,
  parameter int MARGIN    = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  input  logic sync_inv,
  input  logic rate_slow,
  input  logic pair_sel,
  input  logic pair_chg,
  output logic valid,
  output logic bnd_stb,
  output logic frame_pulse
);
  localparam int NOM_MAX = (NOM_SLOW > NOM_FAST) ? NOM_SLOW : NOM_FAST;
  localparam int LIMIT   = NOM_MAX + MARGIN;
  localparam int CW      = $clog2(LIMIT + 1);

  logic          s1, s2, s3;
  logic          armed, pair_q;
  logic [CW-1:0] nom_q, cnt, fcnt;

  wire           sync_edge = s2 & ~s3;
  wire           switch    = pair_chg & (pair_sel != pair_q);
  wire [CW-1:0]  nom_m1    = nom_q - CW'(1);
  wire [CW-1:0]  tmo       = nom_m1 + CW'(MARGIN);
  wire           exact     = (cnt == nom_m1);
  wire [CW-1:0]  fcnt_nx   = (fcnt >= nom_m1) ? '0 : fcnt + CW'(1);

  assign frame_pulse = valid & (fcnt < CW'(PULSE_LEN));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      armed <= 1'b0; pair_q <= 1'b0; valid <= 1'b0; bnd_stb <= 1'b0;
      nom_q <= CW'(NOM_FAST); cnt <= '0; fcnt <= '0;
    end else begin
      s1 <= sync_in ^ sync_inv;
      s2 <= s1;
      s3 <= s2;
      nom_q   <= rate_slow ? CW'(NOM_SLOW) : CW'(NOM_FAST);
      bnd_stb <= sync_edge & ~switch;
      if (switch) begin
        pair_q <= pair_sel;
        armed  <= 1'b0;
        valid  <= 1'b0;
        cnt    <= '0;
        fcnt   <= '0;
      end else if (sync_edge) begin
        cnt   <= '0;
        armed <= 1'b1;
        if (armed) valid <= exact;
        fcnt  <= (armed && exact) ? '0 : fcnt_nx;
      end else begin
        if (cnt != CW'(LIMIT)) cnt <= cnt + CW'(1);
        if (valid && cnt >= tmo) valid <= 1'b0;
        fcnt <= fcnt_nx;
      end
    end
  end

  p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_stb |=> !bnd_stb);

  p_valid_rise_on_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> bnd_stb);

  p_boundary_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && bnd_stb) |-> frame_pulse);

  p_overdue_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cnt > tmo) |=> !valid);

  p_switch_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_chg && pair_sel != pair_q) |=> (!valid && !frame_pulse));

endmodule

// File: tb/frame_pair_checker_test.sv
module frame_pair_checker_test;
  localparam int NF = 1024, NS = 4096, MG = 16, PL = 4;

  logic clk = 0, rst_n = 0, sync_in = 0, sync_inv = 0;
  logic rate_slow = 0, pair_sel = 0, pair_chg = 0;
  logic valid, bnd_stb, frame_pulse;

  frame_pair_checker #(.NOM_FAST(NF), .NOM_SLOW(NS), .MARGIN(MG), .PULSE_LEN(PL)) uut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_inv(sync_inv),
    .rate_slow(rate_slow), .pair_sel(pair_sel), .pair_chg(pair_chg),
    .valid(valid), .bnd_stb(bnd_stb), .frame_pulse(frame_pulse));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, stb_cyc = 0, rise_cyc = 0, next_rise = 0;
  bit exp_q[$];
  bit armed_m = 0;
  int last_per_m = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pop one expected valid per boundary strobe
  always @(negedge clk) begin
    if (rst_n && bnd_stb) begin
      stb_cyc = cyc;
      check(cyc - rise_cyc == 3, sync_inv ? "R2 strobe latency" : "R3 strobe latency",
            cyc - rise_cyc, 3);
      if (exp_q.size() == 0) begin
        check(0, "R3 unexpected strobe", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check(valid == e, rate_slow ? "R6 valid at boundary" : "R4 R5 valid at boundary",
              int'(valid), int'(e));
        if (e) check(frame_pulse == 1'b1, "R7 pulse at boundary", int'(frame_pulse), 1);
      end
    end
  end

  function automatic int nom_m();
    return rate_slow ? NS : NF;
  endfunction

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic lvl(input bit v);
    sync_in = v ^ sync_inv;
  endtask

  // driver: sync rise after exactly 'per' cycles from the previous rise
  task automatic frame(input int per);
    wait_to(next_rise);
    exp_q.push_back(armed_m && last_per_m == nom_m());
    armed_m = 1;
    last_per_m = per;
    rise_cyc = cyc;
    next_rise = cyc + per;
    lvl(1);
    repeat (8) @(negedge clk);
    lvl(0);
  endtask

  task automatic do_reset(input bit inv, input bit slow);
    @(negedge clk);
    rst_n = 0;
    sync_inv = inv;
    rate_slow = slow;
    pair_sel = 0;
    lvl(0);
    exp_q.delete();
    armed_m = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    next_rise = cyc + 4;
  endtask

  task automatic pair_pulse(input bit sel);
    @(negedge clk);
    pair_sel = sel;
    pair_chg = 1;
    @(negedge clk);
    pair_chg = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid == 0 && bnd_stb == 0 && frame_pulse == 0, "R1 during reset",
          {valid, bnd_stb, frame_pulse}, 0);
    rst_n = 1;
    @(negedge clk);
    check(valid == 0 && bnd_stb == 0 && frame_pulse == 0, "R1 after release",
          {valid, bnd_stb, frame_pulse}, 0);
    next_rise = cyc + 2;

    // fast rate: lock, then recurrence and timeout without edges
    frame(NF); frame(NF); frame(NF); frame(NF);
    wait_to(stb_cyc + NF - 1);
    check(frame_pulse == 0, "R7 gap before recurrence", int'(frame_pulse), 0);
    wait_to(stb_cyc + NF);
    check(frame_pulse == 1, "R7 recurrence", int'(frame_pulse), 1);
    wait_to(stb_cyc + NF + PL - 1);
    check(frame_pulse == 1, "R7 pulse last cycle", int'(frame_pulse), 1);
    wait_to(stb_cyc + NF + PL);
    check(frame_pulse == 0, "R7 pulse width", int'(frame_pulse), 0);
    wait_to(stb_cyc + NF + MG - 3);
    check(valid == 1, "R8 still valid before timeout", int'(valid), 1);
    wait_to(stb_cyc + NF + MG + 3);
    check(valid == 0, "R8 timeout", int'(valid), 0);

    // off-by-one periods
    do_reset(0, 0);
    frame(NF); frame(NF + 1); frame(NF); frame(NF - 1); frame(NF); frame(NF); frame(NF);
    wait_to(next_rise - NF + 20);

    // slow rate, inverted polarity
    do_reset(1, 1);
    frame(NS); frame(NS); frame(NS);
    wait_to(next_rise - NS + 20);
    check(valid == 1, "R6 R2 locked at slow rate", int'(valid), 1);

    // pair selection
    do_reset(0, 0);
    frame(NF); frame(NF);
    wait_to(next_rise - NF + 20);
    pair_pulse(0);
    check(valid == 1, "R10 same pair ignored", int'(valid), 1);
    frame(NF);
    wait_to(next_rise - NF + 20);
    pair_pulse(1);
    check(valid == 0 && frame_pulse == 0, "R9 switch clears", {valid, frame_pulse}, 0);
    armed_m = 0;
    frame(NF); frame(NF); frame(NF);
    wait_to(next_rise - NF + 20);
    check(valid == 1, "R9 relock after switch", int'(valid), 1);
    check(exp_q.size() == 0, "R3 missing strobes", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule